// File: doc/BRIEF.md
# Non-Overlapping Phase Strobe Generator

This block paces a small bus-based processor. It runs from one fast reference clock and produces three single-cycle enable strobes per machine step. The action strobe comes first and updates registers. The step strobe follows one cycle later and advances the micro-step counter. The snapshot strobe comes one cycle after that and latches the decode inputs. A one-cycle gap then follows, so the pattern gives the spacing 1 : 1 : 2. The action and snapshot strobes are built from a reference phase bit and a divide-by-two bit, which keeps them apart by construction. All strobes are clock enables in the single clock domain, not derived clocks.

A step starts only at a step boundary. It needs the power-on wait to be over, halt to be low and programming mode to be low. In automatic mode steps follow one another with no pause. In manual mode each rising edge of the single-step button gives exactly one step. Once a step has begun it always runs to its end, whatever happens on halt, prog or the button meanwhile. After the synchronous reset, a counter holds the master reset output high for a set number of cycles. This counter stands in for the analog power-on delay.

Top module: `phase_clkgen`

## Requirements
- R1: After `rst` is released, `master_rst` stays 1 for exactly STARTUP_CYCLES rising edges and is 0 from the next edge on. It stays 0 until `rst` is asserted again.
- R2: While `master_rst` is 1, none of `act_stb`, `step_stb`, `snap_stb` is 1.
- R3: Every step shows `act_stb` in one cycle, `step_stb` in the next and `snap_stb` in the one after. The fourth cycle has no strobe.
- R4: `act_stb` and `snap_stb` are never 1 together, and at most one strobe is 1 in any cycle.
- R5: In automatic mode (`auto_mode`=1) with halt and prog low, the first `act_stb` is seen one edge after `master_rst` falls, and then `act_stb` repeats every 4 cycles.
- R6: Halt is sampled only at a step boundary. A step already started completes with its step and snapshot strobes. No new `act_stb` appears in the cycle after an edge at which `halt` was 1. Automatic stepping resumes at the first edge that samples `halt` low.
- R7: `prog`=1 blocks the start of a new step in the same way as halt.
- R8: In manual mode (`auto_mode`=0), the edge that first samples `man_step` high after it was low starts one step, with `act_stb` visible right after that edge, provided the block is idle and not blocked. Holding the button gives no further steps.
- R9: In manual mode, a button press that is sampled while a step is running, or while halt or prog is high, is dropped and is not remembered for later.
- R10: Asserting `rst` at any time clears all strobes on the next edge and raises `master_rst` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_mode | input | 1 | 1 = free-running steps, 0 = single-step by button |
| man_step | input | 1 | Single-step button, already synchronised and debounced |
| halt | input | 1 | Stop stepping at the next step boundary |
| prog | input | 1 | Programming mode, blocks stepping like halt |
| master_rst | output | 1 | Master reset to the rest of the processor |
| act_stb | output | 1 | Action strobe (first phase of a step) |
| step_stb | output | 1 | Micro-step advance strobe |
| snap_stb | output | 1 | Decode snapshot strobe |

## Verification
Every output is registered. A strobe therefore shows its new value right after the rising edge that sampled the inputs causing it: the press, the boundary or the end of the wait. The bench drives inputs and compares outputs on falling edges only. A bench-side step model advances on each rising edge from the same sampled inputs. It gives the expected value of every output for the following falling edge, and the comparison is made there. The directed checks count edges from each stimulus: STARTUP_CYCLES edges for the end of the wait, one edge for the first action after a press or after release of halt, and then 1, 2 and 4 edges for the step, snapshot and next action.

// File: rtl/phc_pkg.sv
package phc_pkg;
  // Slot order is behaviour: action, step advance, snapshot, gap.
  typedef enum logic [1:0] {
    SL_ACT  = 2'd0,
    SL_STEP = 2'd1,
    SL_SNAP = 2'd2,
    SL_GAP  = 2'd3
  } slot_e;
endpackage

// File: rtl/phc_startup.sv
module phc_startup #(
  parameter int unsigned STARTUP_CYCLES = 250_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic mrst
);
  localparam int unsigned CW = $clog2(STARTUP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STARTUP_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      mrst  <= 1'b1;
    end else if (mrst) begin
      if (cnt_q == LAST) mrst <= 1'b0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_MRST_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
    !mrst |=> !mrst); // R1
endmodule

// File: rtl/phc_trigger.sv
module phc_trigger (
  input  logic clk,
  input  logic rst,
  input  logic auto_mode,
  input  logic man_step,
  input  logic halt,
  input  logic prog,
  input  logic mrst,
  input  logic busy,
  output logic start_req
);
  logic btn_q;
  logic press;
  logic allowed;

  always_ff @(posedge clk) begin
    if (rst) btn_q <= 1'b0;
    else     btn_q <= man_step;
  end

  assign press   = man_step & ~btn_q;
  assign allowed = ~mrst & ~halt & ~prog;

  always_comb begin
    if (auto_mode) start_req = allowed;
    else           start_req = allowed & press & ~busy;
  end
endmodule

// File: rtl/phc_seq.sv
module phc_seq
  import phc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  output logic busy,
  output logic act_stb,
  output logic step_stb,
  output logic snap_stb
);
  slot_e slot_q, slot_d;
  logic  busy_d;
  logic  ref_hi_d;   // reference phase: high in ACT and SNAP slots
  logic  div_d;      // divide-by-two stage, changes while reference is low
  logic  boundary;

  assign boundary = ~busy | (slot_q == SL_GAP);

  always_comb begin
    busy_d = busy;
    slot_d = slot_q;
    if (boundary && start_req) begin
      busy_d = 1'b1;
      slot_d = SL_ACT;
    end else if (busy) begin
      if (slot_q == SL_GAP) busy_d = 1'b0;
      slot_d = slot_e'(slot_q + 2'd1);
    end
  end

  assign ref_hi_d = ~slot_d[0];
  assign div_d    = slot_d[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      slot_q   <= SL_ACT;
      act_stb  <= 1'b0;
      step_stb <= 1'b0;
      snap_stb <= 1'b0;
    end else begin
      busy     <= busy_d;
      slot_q   <= slot_d;
      act_stb  <= busy_d & ref_hi_d & ~div_d;
      snap_stb <= busy_d & ref_hi_d &  div_d;
      step_stb <= busy_d & (slot_d == SL_STEP);
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(act_stb && snap_stb)); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({act_stb, step_stb, snap_stb})); // R4
  AST_ACT_THEN_STEP: assert property (@(posedge clk) disable iff (rst)
    act_stb |=> step_stb); // R3
  AST_STEP_THEN_SNAP: assert property (@(posedge clk) disable iff (rst)
    step_stb |=> snap_stb); // R3
  AST_GAP_AFTER_SNAP: assert property (@(posedge clk) disable iff (rst)
    snap_stb |=> !(act_stb || step_stb || snap_stb)); // R3
endmodule

// File: rtl/phase_clkgen.sv
module phase_clkgen #(
  parameter int unsigned STARTUP_CYCLES = 250_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic auto_mode,
  input  logic man_step,
  input  logic halt,
  input  logic prog,
  output logic master_rst,
  output logic act_stb,
  output logic step_stb,
  output logic snap_stb
);
  logic start_req;
  logic busy;

  phc_startup #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_startup (
    .clk  (clk),
    .rst  (rst),
    .mrst (master_rst)
  );

  phc_trigger u_trig (
    .clk       (clk),
    .rst       (rst),
    .auto_mode (auto_mode),
    .man_step  (man_step),
    .halt      (halt),
    .prog      (prog),
    .mrst      (master_rst),
    .busy      (busy),
    .start_req (start_req)
  );

  phc_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .busy      (busy),
    .act_stb   (act_stb),
    .step_stb  (step_stb),
    .snap_stb  (snap_stb)
  );

  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    master_rst |-> !(act_stb || step_stb || snap_stb)); // R2
  AST_HALT_NO_START: assert property (@(posedge clk) disable iff (rst)
    halt |=> !act_stb); // R6
  AST_PROG_NO_START: assert property (@(posedge clk) disable iff (rst)
    prog |=> !act_stb); // R7
  AST_MANUAL_NEEDS_BTN: assert property (@(posedge clk) disable iff (rst)
    (!auto_mode && $past(!auto_mode) && act_stb) |-> $past(man_step)); // R8
endmodule

// File: tb/tb_phase_clkgen.sv
module tb_phase_clkgen;
  localparam int unsigned N = 16;
  localparam time CLK_P = 4ns;

  logic clk = 1'b0;
  logic rst = 1'b1, auto_mode = 1'b1, man_step = 1'b0, halt = 1'b0, prog = 1'b0;
  logic master_rst, act_stb, step_stb, snap_stb;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  phase_clkgen #(.STARTUP_CYCLES(N)) dut (
    .clk(clk), .rst(rst), .auto_mode(auto_mode), .man_step(man_step),
    .halt(halt), .prog(prog), .master_rst(master_rst),
    .act_stb(act_stb), .step_stb(step_stb), .snap_stb(snap_stb)
  );

  // Bench step model, written from the requirements.
  int   m_cnt  = 0;
  logic m_mrst = 1'b1, m_busy = 1'b0, m_btnq = 1'b0;
  int   m_slot = 0;

  function automatic logic exp_strobe(input int which);
    return m_busy && (m_slot == which);
  endfunction

  always @(posedge clk) begin
    logic ok, req;
    if (rst) begin
      m_cnt = 0; m_mrst = 1'b1; m_busy = 1'b0; m_slot = 0; m_btnq = 1'b0;
    end else begin
      ok  = !m_mrst && !halt && !prog;
      req = auto_mode ? ok : (ok && man_step && !m_btnq && !m_busy);
      m_btnq = man_step;
      if (m_mrst) begin
        if (m_cnt == N - 1) m_mrst = 1'b0; else m_cnt++;
      end
      if ((!m_busy || m_slot == 3) && req) begin
        m_busy = 1'b1; m_slot = 0;
      end else if (m_busy) begin
        if (m_slot == 3) m_busy = 1'b0;
        m_slot = (m_slot + 1) % 4;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Advance one edge and compare all outputs with the model at the falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check("R1", "master_rst model", master_rst, m_mrst);
    check("R3", "act_stb model", act_stb, exp_strobe(0));
    check("R3", "step_stb model", step_stb, exp_strobe(1));
    check("R3", "snap_stb model", snap_stb, exp_strobe(2));
    check("R4", "strobe overlap", int'(act_stb) + int'(step_stb) + int'(snap_stb) > 1, 0);
  endtask

  task automatic count_acts(input int n, output int acts);
    acts = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (act_stb) acts++;
    end
  endtask

  initial begin
    int acts;
    int strobes;
    @(negedge clk);
    tick(); tick(); tick();
    check("R10", "master_rst in reset", master_rst, 1);
    check("R10", "strobes in reset", act_stb | step_stb | snap_stb, 0);
    rst = 1'b0;

    // R1/R2: startup wait
    strobes = 0;
    for (int i = 0; i < int'(N) - 1; i++) begin
      tick();
      if (act_stb | step_stb | snap_stb) strobes++;
    end
    check("R1", "master_rst before expiry", master_rst, 1);
    check("R2", "strobes during wait", strobes, 0);
    tick();
    check("R1", "master_rst after expiry", master_rst, 0);

    // R5: automatic run
    tick();
    check("R5", "first act after wait", act_stb, 1);
    count_acts(40, acts);
    check("R5", "acts in 40 cycles", acts, 10);

    // R6: halt raised just after an action
    halt = 1'b1;
    tick(); check("R6", "step completes under halt", step_stb, 1);
    tick(); check("R6", "snap completes under halt", snap_stb, 1);
    count_acts(10, acts);
    check("R6", "no act while halted", acts, 0);
    halt = 1'b0;
    tick(); check("R6", "resume after halt", act_stb, 1);

    // R7: prog
    prog = 1'b1;
    tick(); check("R7", "step completes under prog", step_stb, 1);
    count_acts(12, acts);
    check("R7", "no act under prog", acts, 0);

    // R8: manual mode
    prog = 1'b0; auto_mode = 1'b0;
    count_acts(6, acts);
    check("R8", "no act without press", acts, 0);
    man_step = 1'b1;
    tick(); check("R8", "act on press edge", act_stb, 1);
    count_acts(15, acts);
    check("R8", "held button no repeat", acts, 0);
    man_step = 1'b0; tick();

    // R9: press during a step
    man_step = 1'b1; tick(); check("R8", "second press starts", act_stb, 1);
    man_step = 1'b0; tick();
    man_step = 1'b1; tick(); check("R9", "snap during busy press", snap_stb, 1);
    count_acts(6, acts);
    check("R9", "busy press dropped", acts, 0);
    man_step = 1'b0; tick();

    // R9: press while halted
    halt = 1'b1; man_step = 1'b1; tick();
    man_step = 1'b0; tick();
    halt = 1'b0;
    count_acts(6, acts);
    check("R9", "halted press not remembered", acts, 0);

    // R10: reset in the middle of running
    auto_mode = 1'b1;
    tick(); check("R10", "auto restart", act_stb, 1);
    tick();
    rst = 1'b1; tick();
    check("R10", "master_rst reasserted", master_rst, 1);
    check("R10", "strobes cleared", act_stb | step_stb | snap_stb, 0);
    rst = 1'b0;

    // Random phase against the model
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 19) == 0) halt = ~halt;
      if ($urandom_range(0, 39) == 0) prog = ~prog;
      if ($urandom_range(0, 59) == 0) auto_mode = ~auto_mode;
      if ($urandom_range(0, 3) == 0) man_step = ~man_step;
      rst = ($urandom_range(0, 599) == 0);
      tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule